// File: doc/BRIEF.md
# Two-Port GPIO Expander Register Core

This core holds the register state behind a two-port, byte-wide general-purpose I/O expander and turns it into per-pin controls for tri-state pads. A serial front end (outside this block) reaches it through a plain synchronous register bus: a command index, write data, a write strobe and combinational read data. Every pin can be an input or an output, every sampled input bit can be complemented on its way back to the bus, and every output pin drives the level held in its output register.

Pad levels enter through a two-flop synchronizer before any inversion is applied. Reading an input port always shows the real pad level, even for a pin currently driven as an output. Output enables are registered and follow the direction registers with a one-cycle lag. The asynchronous active-low reset is released through a local reset synchronizer, and it returns every register to its default: all pins are high-impedance inputs, all output bits are ones, and no bit is inverted.

Top module: `gpio_xp_regbank`

## Requirements
- R1: While the core is in reset and right after reset, pin_oe is all zeros, pin_out is all ones, reads at indices 2 and 3 return 0xFF, reads at indices 4 and 5 return 0x00, and reads at indices 6 and 7 return 0xFF.
- R2: A write at index 4 (port 0) or 5 (port 1) stores the polarity byte. The next read at that index returns the stored byte.
- R3: A read at index 0 (port 0) or 1 (port 1) returns the pad level of each bit, XORed with the matching polarity bit: a 1 complements the bit and a 0 passes it unchanged. Bit i of port p is pin_in[8p+i]. A pad change is seen in the read data two clock edges after it is applied.
- R4: A write at index 6 or 7 stores the direction byte, where a 1 means input and a 0 means output. The next read at that index returns the stored byte. pin_oe bit 8p+i equals the inverse of direction bit i of port p, and it changes one clock after the direction register changes.
- R5: A write at index 2 or 3 stores the output byte. pin_out bits of that port show the stored byte from the next clock on, and the next read at that index returns it.
- R6: Writes at indices 0 and 1 change no register: pin_out, pin_oe and all reads are as if the write had not happened.
- R7: Reads at any index above 7 return zero, and writes there change no register.
- R8: An input-port read reflects the synchronized pad level whatever the pin's direction, including pins enabled as outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (8) | Command index for read and write |
| bus_wdata | input | PORT_W (8) | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock |
| bus_rdata | output | PORT_W (8) | Read data for the current command index |
| pin_in | input | NUM_PORTS*PORT_W (16) | Pad input levels, port p bit i at 8p+i |
| pin_oe | output | NUM_PORTS*PORT_W (16) | Per-pin output enable toward the pad |
| pin_out | output | NUM_PORTS*PORT_W (16) | Per-pin output level toward the pad |

## Verification
A corrupted direction bit shows on pin_oe one clock after the faulty register update and on the direction readback at once. A wrong output bit shows on pin_out in the same cycle. A stale synchronizer stage or a mis-applied polarity bit shows only on input-port reads, two edges after the pad change. The reference model tracks the register state and the synchronizer pipeline every clock, so any such divergence is reported in the cycle it first reaches a port. A write decoded at the wrong index shows as an unexpected readback or pad change on the very next cycle.

// File: rtl/gpio_xp_pkg.sv
package gpio_xp_pkg;

  // Register groups; each group holds one register per port, consecutively.
  localparam int unsigned GRP_IN   = 0;
  localparam int unsigned GRP_OUT  = 1;
  localparam int unsigned GRP_INV  = 2;
  localparam int unsigned GRP_CFG  = 3;
  localparam int unsigned NUM_GRPS = 4;

  typedef struct packed {
    logic wr_out;
    logic wr_inv;
    logic wr_cfg;
  } port_wr_t;

  function automatic int unsigned cmd_index(input int unsigned grp,
                                            input int unsigned port,
                                            input int unsigned nports);
    return grp * nports + port;
  endfunction

endpackage

// File: rtl/gpio_xp_rstsync.sv
module gpio_xp_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_xp_sync.sv
module gpio_xp_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_xp_port.sv
module gpio_xp_port
  import gpio_xp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  port_wr_t     wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] out_q,
  output logic [W-1:0] inv_q,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] in_val,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out
);

  logic [W-1:0] out_d;
  logic [W-1:0] inv_d;
  logic [W-1:0] cfg_d;
  logic [W-1:0] oe_q;
  logic [W-1:0] oe_d;

  // Next-state with explicit clock enables per register.
  always_comb begin
    out_d = out_q;
    inv_d = inv_q;
    cfg_d = cfg_q;
    if (wr.wr_out) out_d = wdata;
    if (wr.wr_inv) inv_d = wdata;
    if (wr.wr_cfg) cfg_d = wdata;
    // Enable is the registered complement of the direction bit.
    oe_d = ~cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '1;
      inv_q <= '0;
      cfg_q <= '1;
      oe_q  <= '0;
    end else begin
      out_q <= out_d;
      inv_q <= inv_d;
      cfg_q <= cfg_d;
      oe_q  <= oe_d;
    end
  end

  assign in_val  = pin_sync ^ inv_q;
  assign pad_oe  = oe_q;
  assign pad_out = out_q;

endmodule

// File: rtl/gpio_xp_rdmux.sv
module gpio_xp_rdmux
  import gpio_xp_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NUM_PORTS*W-1:0] in_all,
  input  logic [NUM_PORTS*W-1:0] out_all,
  input  logic [NUM_PORTS*W-1:0] inv_all,
  input  logic [NUM_PORTS*W-1:0] cfg_all,
  output logic [W-1:0]           rdata
);

  // Unmatched indices fall through to zero.
  always_comb begin
    rdata = '0;
    for (int unsigned p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(cmd_index(GRP_IN, p, NUM_PORTS)))  rdata = in_all[p*W +: W];
      if (addr == ADDR_W'(cmd_index(GRP_OUT, p, NUM_PORTS))) rdata = out_all[p*W +: W];
      if (addr == ADDR_W'(cmd_index(GRP_INV, p, NUM_PORTS))) rdata = inv_all[p*W +: W];
      if (addr == ADDR_W'(cmd_index(GRP_CFG, p, NUM_PORTS))) rdata = cfg_all[p*W +: W];
    end
  end

endmodule

// File: rtl/gpio_xp_regbank.sv
module gpio_xp_regbank
  import gpio_xp_pkg::*;
#(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [PORT_W-1:0]             bus_wdata,
  input  logic                          bus_we,
  output logic [PORT_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out
);

  localparam int unsigned PINS = NUM_PORTS * PORT_W;

  logic            rst_core_n;
  logic [PINS-1:0] pin_sync;
  logic [PINS-1:0] in_all;
  logic [PINS-1:0] out_all;
  logic [PINS-1:0] inv_all;
  logic [PINS-1:0] cfg_all;

  gpio_xp_rstsync #(
    .STAGES (2)
  ) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  gpio_xp_sync #(
    .W      (PINS),
    .STAGES (SYNC_LEN)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .d_async (pin_in),
    .q_sync  (pin_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    port_wr_t wr;

    // Input-group indices have no write enable: they are read-only.
    always_comb begin
      wr.wr_out = bus_we && (bus_addr == ADDR_W'(cmd_index(GRP_OUT, p, NUM_PORTS)));
      wr.wr_inv = bus_we && (bus_addr == ADDR_W'(cmd_index(GRP_INV, p, NUM_PORTS)));
      wr.wr_cfg = bus_we && (bus_addr == ADDR_W'(cmd_index(GRP_CFG, p, NUM_PORTS)));
    end

    gpio_xp_port #(
      .W (PORT_W)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .wr       (wr),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync[p*PORT_W +: PORT_W]),
      .out_q    (out_all[p*PORT_W +: PORT_W]),
      .inv_q    (inv_all[p*PORT_W +: PORT_W]),
      .cfg_q    (cfg_all[p*PORT_W +: PORT_W]),
      .in_val   (in_all[p*PORT_W +: PORT_W]),
      .pad_oe   (pin_oe[p*PORT_W +: PORT_W]),
      .pad_out  (pin_out[p*PORT_W +: PORT_W])
    );
  end

  gpio_xp_rdmux #(
    .W         (PORT_W),
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
  ) u_rdmux (
    .addr    (bus_addr),
    .in_all  (in_all),
    .out_all (out_all),
    .inv_all (inv_all),
    .cfg_all (cfg_all),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/gpio_xp_checker.sv
module gpio_xp_checker
  import gpio_xp_pkg::*;
#(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned ADDR_W    = 8
) (
  input logic                        clk,
  input logic                        rst_core_n,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [PORT_W-1:0]           bus_wdata,
  input logic                        bus_we,
  input logic [PORT_W-1:0]           bus_rdata,
  input logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  input logic [NUM_PORTS*PORT_W-1:0] pin_out
);

  localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(cmd_index(GRP_IN, 0, NUM_PORTS));
  localparam logic [ADDR_W-1:0] A_IN1  = ADDR_W'(cmd_index(GRP_IN, 1, NUM_PORTS));
  localparam logic [ADDR_W-1:0] A_OUT0 = ADDR_W'(cmd_index(GRP_OUT, 0, NUM_PORTS));
  localparam logic [ADDR_W-1:0] A_INV0 = ADDR_W'(cmd_index(GRP_INV, 0, NUM_PORTS));
  localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(cmd_index(GRP_CFG, 0, NUM_PORTS));
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(NUM_GRPS * NUM_PORTS - 1);

  assert_inv_readback_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_INV0) ##1 (bus_addr == A_INV0) |-> bus_rdata == $past(bus_wdata))
    else $error("polarity readback differs from the written byte");

  assert_oe_lags_cfg_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_CFG0) |=> ##1 (pin_oe[PORT_W-1:0] == ~$past(bus_wdata, 2)))
    else $error("output enable does not follow the direction write");

  assert_out_drive_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_OUT0) |=> pin_out[PORT_W-1:0] == $past(bus_wdata))
    else $error("pad level does not follow the output write");

  assert_input_ro_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && (bus_addr == A_IN0 || bus_addr == A_IN1)) |=> $stable(pin_out))
    else $error("write to an input index changed the pads");

  assert_high_idx_zero_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr > A_LAST) |-> bus_rdata == '0)
    else $error("unmapped index returned nonzero data");

endmodule

bind gpio_xp_regbank gpio_xp_checker #(
  .PORT_W    (PORT_W),
  .NUM_PORTS (NUM_PORTS),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_we     (bus_we),
  .bus_rdata  (bus_rdata),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out)
);

// File: tb/gpio_xp_regbank_tb.sv
`timescale 1ns/1ps
module gpio_xp_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_oe;
  logic [15:0] pin_out;

  always #2.5 clk = ~clk;

  gpio_xp_regbank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
  );

  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    active = 0;
  bit    done   = 0;
  string req    = "R1";

  // Behavioural reference state
  logic [7:0]  m_out [2];
  logic [7:0]  m_inv [2];
  logic [7:0]  m_cfg [2];
  logic [7:0]  m_s1  [2];
  logic [7:0]  m_s2  [2];
  logic [15:0] m_oe;
  int          m_rcnt = 0;

  task automatic m_defaults();
    for (int p = 0; p < 2; p++) begin
      m_out[p] = 8'hFF; m_inv[p] = 8'h00; m_cfg[p] = 8'hFF;
      m_s1[p] = 8'h00;  m_s2[p] = 8'h00;
    end
    m_oe = 16'h0000;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rcnt = 0;
      m_defaults();
    end else if (m_rcnt < 2) begin
      m_rcnt++;
      m_defaults();
    end else begin
      for (int p = 0; p < 2; p++) begin
        m_oe[p*8 +: 8] = ~m_cfg[p];
        m_s2[p] = m_s1[p];
        m_s1[p] = pin_in[p*8 +: 8];
      end
      if (bus_we) begin
        case (bus_addr)
          8'd2: m_out[0] = bus_wdata;
          8'd3: m_out[1] = bus_wdata;
          8'd4: m_inv[0] = bus_wdata;
          8'd5: m_inv[1] = bus_wdata;
          8'd6: m_cfg[0] = bus_wdata;
          8'd7: m_cfg[1] = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'd0: return m_s2[0] ^ m_inv[0];
      8'd1: return m_s2[1] ^ m_inv[1];
      8'd2: return m_out[0];
      8'd3: return m_out[1];
      8'd4: return m_inv[0];
      8'd5: return m_inv[1];
      8'd6: return m_cfg[0];
      8'd7: return m_cfg[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp16(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare on every clock, away from the rising edge.
  always @(negedge clk) begin
    if (active) begin
      cmp16("rdata",   {8'h00, bus_rdata}, {8'h00, exp_rd(bus_addr)});
      cmp16("pin_oe",  pin_oe,  m_oe);
      cmp16("pin_out", pin_out, {m_out[1], m_out[0]});
    end
  end

  task automatic step(input logic [7:0] a, input logic [7:0] d, input bit we);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = we;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 8'd0; bus_wdata = 8'd0; bus_we = 1'b0;
    pin_in = 16'hA55A;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(8'd0, 8'd0, 0);
    step(8'd0, 8'd0, 0);
    step(8'd0, 8'd0, 0);
    active = 1;

    // R1: reset defaults readable on every index
    req = "R1";
    for (int a = 0; a < 8; a++) step(8'(a), 8'h00, 0);

    // R2: polarity registers store and read back
    req = "R2";
    step(8'd4, 8'h3C, 1); step(8'd4, 8'h00, 0);
    step(8'd5, 8'hC1, 1); step(8'd5, 8'h00, 0);

    // R3: inverted pad readback with two-edge latency
    req = "R3";
    for (int k = 0; k < 6; k++) begin
      pin_in = 16'(k * 16'h2F1B + 16'h0707);
      step(8'(k % 2), 8'h00, 0);
      step(8'd0, 8'h00, 0);
      step(8'd1, 8'h00, 0);
    end

    // R4: direction writes and lagged output enable
    req = "R4";
    step(8'd6, 8'h0F, 1); step(8'd6, 8'h00, 0); step(8'd6, 8'h00, 0);
    step(8'd7, 8'h00, 1); step(8'd7, 8'hAA, 1); step(8'd7, 8'h00, 0);
    step(8'd0, 8'h00, 0);

    // R5: output registers drive the pads
    req = "R5";
    step(8'd2, 8'h12, 1); step(8'd2, 8'h00, 0);
    step(8'd3, 8'h87, 1); step(8'd3, 8'h00, 0);

    // R6: input indices are read-only
    req = "R6";
    step(8'd0, 8'h5A, 1); step(8'd1, 8'hF0, 1);
    for (int a = 0; a < 8; a++) step(8'(a), 8'h00, 0);

    // R7: indices above 7 read zero and ignore writes
    req = "R7";
    step(8'd8, 8'h00, 1); step(8'd8, 8'h00, 0);
    step(8'd200, 8'h77, 1); step(8'd255, 8'h11, 1);
    for (int a = 0; a < 8; a++) step(8'(a), 8'h00, 0);

    // R8: pads read back while enabled as outputs
    req = "R8";
    step(8'd6, 8'h00, 1); step(8'd7, 8'h00, 1); step(8'd4, 8'h00, 1);
    pin_in = 16'h6C93;
    step(8'd0, 8'h00, 0); step(8'd0, 8'h00, 0); step(8'd1, 8'h00, 0);
    step(8'd0, 8'h00, 0);

    // R2: mixed traffic against the model
    req = "R2";
    for (int k = 0; k < 400; k++) begin
      if (k % 5 == 0) pin_in = 16'($urandom);
      step(8'($urandom_range(0, 11)), 8'($urandom), bit'($urandom_range(0, 1)));
    end
    step(8'd0, 8'h00, 0);
    step(8'd0, 8'h00, 0);

    active = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog: actual=hung expected=finished", req);
      summary();
      $finish;
    end
  end

endmodule